// File: doc/BRIEF.md
# ADC Scan Sequencer Register Front End

This block sits between a byte-wide host register port and a 12-bit sampling converter that has 16 multiplexed inputs. The host programs a scan window as a pair of channel numbers and a gain code for each channel. It then picks a trigger source: software, an external pulse or a pacer pulse. Each accepted trigger starts one conversion on the current channel. When the conversion completes, the channel moves one step through the window and wraps back to its start.

The converter is modelled as a request/done handshake. The block raises `conv_req` for one cycle and holds the channel number and gain code stable. It waits for `conv_done` together with a 12-bit `conv_data`. Each finished sample becomes a 16-bit result word with the channel tag in the low nibble and the converted value above it. The host can read that word back as two bytes. Completion sets an end-of-conversion flag and a pending flag. The pending flag drives the interrupt output when interrupts are enabled.

The host uses simple strobes. Reads are combinational from `bus_addr`, and a write takes effect on the clock edge where `bus_wr` is high.

Top module: `adc_scan_regs`

## Requirements
- R1: A write to address 0x2 sets the window start to `bus_wdata[3:0]` and the window end to `bus_wdata[7:4]`. It also moves the next-channel pointer to the window start. Reading address 0x2 returns `{end, start}`.
- R2: A write to address 0x1 stores `bus_wdata[3:0]` as the gain code of the channel given by the low nibble of the most recent address-0x2 write. `conv_gain` presents the stored code of the channel being converted.
- R3: When the trigger field is 1 (software), any write to address 0x0 while idle starts a conversion. `conv_req` is high for exactly one cycle, and `conv_chan` shows the next-channel pointer.
- R4: A result word is `{conv_data, channel}`, with the channel tag in bits [3:0]. It appears on `res_word` with a one-cycle `res_valid`. Reading address 0x0 returns bits [7:0] and reading address 0x1 returns bits [15:8].
- R5: Reading address 0x8 returns status. Bits [3:0] are the next channel, bit 4 is interrupt pending, bit 5 is `se_mode`, bit 6 is `uni_mode`, and bit 7 is end of conversion (set on completion, cleared when the next conversion starts).
- R6: Any write to address 0x8 clears the pending flag, unless a conversion completes in the same cycle.
- R7: The control register at address 0x9 reads back as written, except that bit 3 reads 0. Bits [1:0] select the trigger (0 off, 1 software, 2 external, 3 pacer), bit 2 is DMA enable, bits [6:4] drive `irq_line`, and bit 7 is interrupt enable.
- R8: After each conversion the next channel becomes the converted channel plus one. When the converted channel equals the window end, it becomes the window start. A window whose start is above its end runs through 15 and on to 0.
- R9: A rising edge on `ext_trig` starts a conversion only in mode 2, and one on `pacer_trig` only in mode 3. A software write starts one only in mode 1. A trigger that arrives while a conversion is busy is ignored. Mode 0 starts nothing.
- R10: `irq_out` is high exactly while interrupt enable is set and the pending flag is set.
- R11: After reset, control is 0, the window is 0..0, the next channel is 0, the flags are clear and `irq_out` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| ext_trig | input | 1 | External trigger, rising edge |
| pacer_trig | input | 1 | Pacer trigger, rising edge |
| se_mode | input | 1 | Single-ended input strap |
| uni_mode | input | 1 | Unipolar input strap |
| conv_req | output | 1 | One-cycle conversion request |
| conv_chan | output | 4 | Channel being converted |
| conv_gain | output | 4 | Gain code of that channel |
| conv_done | input | 1 | Conversion complete |
| conv_data | input | 12 | Conversion value |
| res_valid | output | 1 | One-cycle result strobe |
| res_word | output | 16 | Last result word |
| irq_line | output | 3 | IRQ line select from control |
| irq_out | output | 1 | Interrupt request |

## Verification
Several properties are checked on every cycle. A request lasts one cycle and is never issued while busy. The interrupt never rises without its enable. Each result tag matches the channel that was requested. The step or wrap of the channel pointer is checked, as is the effect of a status write on the pending flag. Other behaviour can only be shown by the bench's scenarios. These cover the gain codes reaching the converter per channel, the byte split of the result on reads, wrap through channel 15, trigger pulses ignored in the wrong mode or while busy, and the status layout including the straps.

// File: rtl/adc_scan_pkg.sv
// Shared constants for the ADC scan sequencer.
// Assumes a 4-bit register address space and byte-wide data.
package adc_scan_pkg;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] OFS_RES_LO = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_RES_HI = 4'h1;
    localparam logic [ADDR_W-1:0] OFS_WINDOW = 4'h2;
    localparam logic [ADDR_W-1:0] OFS_STATUS = 4'h8;
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 4'h9;

    typedef enum logic [1:0] {
        TRG_OFF   = 2'd0,
        TRG_SOFT  = 2'd1,
        TRG_EXT   = 2'd2,
        TRG_PACER = 2'd3
    } trig_sel_e;
endpackage

// File: rtl/adc_scan_regfile.sv
// Holds the control register, the scan window bounds and the per-channel
// gain code table. Assumes write strobes are already decoded by the parent.
module adc_scan_regfile #(
    parameter int CH_W   = 4,
    parameter int GAIN_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic              win_wr,
    input  logic              gain_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CH_W-1:0]   sel_chan,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [CH_W-1:0]   win_first,
    output logic [CH_W-1:0]   win_last,
    output logic [GAIN_W-1:0] sel_gain
);
    localparam int N_CH = 1 << CH_W;

    logic [CH_W-1:0]             gain_tgt_q;
    logic [N_CH-1:0][GAIN_W-1:0] gain_q;

    // Control register; bit 3 is not implemented.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (ctrl_wr)
            ctrl_q <= wdata & ~DATA_W'(8'h08);
    end

    // Window bounds and gain target follow each window write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_first  <= '0;
            win_last   <= '0;
            gain_tgt_q <= '0;
        end else if (win_wr) begin
            win_first  <= wdata[CH_W-1:0];
            win_last   <= wdata[2*CH_W-1:CH_W];
            gain_tgt_q <= wdata[CH_W-1:0];
        end
    end

    // Gain table: one code per channel, written through the target pointer.
    always_ff @(posedge clk) begin
        if (!rst_n)
            gain_q <= '0;
        else if (gain_wr)
            for (int c = 0; c < N_CH; c++)
                if (gain_tgt_q == CH_W'(c))
                    gain_q[c] <= wdata[GAIN_W-1:0];
    end

    assign sel_gain = gain_q[sel_chan];
endmodule

// File: rtl/adc_scan_trig.sv
// Turns the selected trigger source into a single start pulse.
// Assumes external and pacer inputs are synchronous; acts on rising edges.
module adc_scan_trig
    import adc_scan_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic       soft_hit,
    input  logic       ext_trig,
    input  logic       pacer_trig,
    output logic       start
);
    logic ext_d, pacer_d;

    // Remember last level of each hardware trigger for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_d   <= 1'b0;
            pacer_d <= 1'b0;
        end else begin
            ext_d   <= ext_trig;
            pacer_d <= pacer_trig;
        end
    end

    // Pick the event belonging to the active source.
    always_comb begin
        unique case (trig_sel_e'(mode))
            TRG_SOFT:  start = soft_hit;
            TRG_EXT:   start = ext_trig & ~ext_d;
            TRG_PACER: start = pacer_trig & ~pacer_d;
            default:   start = 1'b0;
        endcase
    end
endmodule

// File: rtl/adc_scan_seq.sv
// Conversion sequencer: issues requests, captures results, steps the
// channel through the window and keeps the end/pending flags.
// Assumes conv_done is only meaningful while a conversion is busy.
module adc_scan_seq #(
    parameter int CH_W  = 4,
    parameter int ADC_W = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  win_wr,
    input  logic [CH_W-1:0]       win_first_new,
    input  logic [CH_W-1:0]       win_first,
    input  logic [CH_W-1:0]       win_last,
    input  logic                  stat_wr,
    input  logic                  conv_done,
    input  logic [ADC_W-1:0]      conv_data,
    output logic                  busy,
    output logic                  conv_req,
    output logic [CH_W-1:0]       cur_chan,
    output logic                  eoc,
    output logic                  pend,
    output logic                  res_valid,
    output logic [ADC_W+CH_W-1:0] res_word
);
    logic finish;
    logic [CH_W-1:0] step_chan;

    assign finish    = busy & conv_done;
    assign step_chan = (cur_chan == win_last) ? win_first : cur_chan + 1'b1;

    // Handshake, result capture, flags and channel pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            conv_req  <= 1'b0;
            cur_chan  <= '0;
            eoc       <= 1'b0;
            pend      <= 1'b0;
            res_valid <= 1'b0;
            res_word  <= '0;
        end else begin
            conv_req  <= 1'b0;
            res_valid <= 1'b0;
            if (stat_wr)
                pend <= 1'b0;
            if (!busy && start) begin
                busy     <= 1'b1;
                conv_req <= 1'b1;
                eoc      <= 1'b0;
            end else if (finish) begin
                busy      <= 1'b0;
                res_word  <= {conv_data, cur_chan};
                res_valid <= 1'b1;
                eoc       <= 1'b1;
                pend      <= 1'b1;
                cur_chan  <= step_chan;
            end
            if (win_wr)
                cur_chan <= win_first_new;
        end
    end
endmodule

// File: rtl/adc_scan_regs.sv
// Top of the ADC scan sequencer: decodes byte register strobes, muxes
// read data and ties the register file, trigger select and sequencer.
// Assumes combinational reads and single-cycle write strobes.
module adc_scan_regs
    import adc_scan_pkg::*;
#(
    parameter int CH_W   = 4,
    parameter int ADC_W  = 12,
    parameter int GAIN_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    input  logic                  bus_wr,
    output logic [DATA_W-1:0]     bus_rdata,
    input  logic                  ext_trig,
    input  logic                  pacer_trig,
    input  logic                  se_mode,
    input  logic                  uni_mode,
    output logic                  conv_req,
    output logic [CH_W-1:0]       conv_chan,
    output logic [GAIN_W-1:0]     conv_gain,
    input  logic                  conv_done,
    input  logic [ADC_W-1:0]      conv_data,
    output logic                  res_valid,
    output logic [ADC_W+CH_W-1:0] res_word,
    output logic [2:0]            irq_line,
    output logic                  irq_out
);
    localparam int RES_W = ADC_W + CH_W;

    logic              soft_hit, win_wr, gain_wr, stat_wr, ctrl_wr;
    logic [DATA_W-1:0] ctrl_q;
    logic [CH_W-1:0]   win_first, win_last, cur_chan;
    logic              start, busy, eoc, pend;

    // Write strobe decode.
    assign soft_hit = bus_wr && bus_addr == OFS_RES_LO;
    assign gain_wr  = bus_wr && bus_addr == OFS_RES_HI;
    assign win_wr   = bus_wr && bus_addr == OFS_WINDOW;
    assign stat_wr  = bus_wr && bus_addr == OFS_STATUS;
    assign ctrl_wr  = bus_wr && bus_addr == OFS_CTRL;

    adc_scan_regfile #(.CH_W(CH_W), .GAIN_W(GAIN_W), .DATA_W(DATA_W)) u_regs (
        .clk, .rst_n, .ctrl_wr, .win_wr, .gain_wr,
        .wdata(bus_wdata), .sel_chan(cur_chan),
        .ctrl_q, .win_first, .win_last, .sel_gain(conv_gain)
    );

    adc_scan_trig u_trig (
        .clk, .rst_n, .mode(ctrl_q[1:0]), .soft_hit,
        .ext_trig, .pacer_trig, .start
    );

    adc_scan_seq #(.CH_W(CH_W), .ADC_W(ADC_W)) u_seq (
        .clk, .rst_n, .start, .win_wr,
        .win_first_new(bus_wdata[CH_W-1:0]), .win_first, .win_last,
        .stat_wr, .conv_done, .conv_data, .busy, .conv_req, .cur_chan,
        .eoc, .pend, .res_valid, .res_word
    );

    assign conv_chan = cur_chan;
    assign irq_line  = ctrl_q[6:4];
    assign irq_out   = ctrl_q[7] & pend;

    // Read data select by address.
    always_comb begin
        unique case (bus_addr)
            OFS_RES_LO: bus_rdata = res_word[7:0];
            OFS_RES_HI: bus_rdata = res_word[RES_W-1 -: 8];
            OFS_WINDOW: bus_rdata = {win_last, win_first};
            OFS_STATUS: bus_rdata = {eoc, uni_mode, se_mode, pend, cur_chan};
            OFS_CTRL:   bus_rdata = ctrl_q;
            default:    bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/adc_scan_chk.sv
// Protocol and sequencing checks for adc_scan_regs, attached by bind.
module adc_scan_chk #(
    parameter int CH_W  = 4,
    parameter int RES_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             conv_req,
    input logic             busy,
    input logic             conv_done,
    input logic             irq_out,
    input logic             irq_en,
    input logic             pend,
    input logic             stat_wr,
    input logic             win_wr,
    input logic             res_valid,
    input logic [RES_W-1:0] res_word,
    input logic [CH_W-1:0]  conv_chan,
    input logic [CH_W-1:0]  win_first,
    input logic [CH_W-1:0]  win_last
);
    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |=> !conv_req); // R3
    AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !conv_done) |=> !conv_req); // R9
    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (irq_en && pend)); // R10
    AST_TAG_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> res_word[CH_W-1:0] == $past(conv_chan)); // R4
    AST_CHAN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !$past(win_wr)) |->
        conv_chan == (($past(conv_chan) == win_last) ? win_first
                                                     : $past(conv_chan) + 1'b1)); // R8
    AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && !(busy && conv_done)) |=> !pend); // R6
endmodule

bind adc_scan_regs adc_scan_chk #(.CH_W(CH_W), .RES_W(RES_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .conv_req(conv_req), .busy(busy),
    .conv_done(conv_done), .irq_out(irq_out), .irq_en(ctrl_q[7]),
    .pend(pend), .stat_wr(stat_wr), .win_wr(win_wr), .res_valid(res_valid),
    .res_word(res_word), .conv_chan(conv_chan), .win_first(win_first),
    .win_last(win_last)
);

// File: tb/sim_adc_scan_regs.sv
// Scoreboard bench: driver tasks queue expected result words, a converter
// model answers requests, and a monitor compares each result strobe.
module sim_adc_scan_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_rdata;
    logic        ext_trig = 1'b0, pacer_trig = 1'b0;
    logic        se_mode = 1'b1, uni_mode = 1'b0;
    logic        conv_req, conv_done;
    logic [3:0]  conv_chan, conv_gain;
    logic [11:0] conv_data;
    logic        res_valid, irq_out;
    logic [15:0] res_word;
    logic [2:0]  irq_line;

    int n_chk = 0, n_bad = 0, n_req = 0;
    bit finished = 0;
    logic [15:0] exp_q[$];
    logic [3:0]  m_first = 0, m_last = 0, m_cur = 0;
    logic [7:0]  rv;

    always #2 clk = ~clk;

    adc_scan_regs u0 (.*);

    function automatic logic [3:0] gain_of(logic [3:0] ch);
        return ch ^ 4'h9;
    endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic set_window(logic [3:0] f, logic [3:0] l);
        wr(4'h2, {l, f});
        m_first = f; m_last = l; m_cur = f;
    endtask

    task automatic expect_one();
        exp_q.push_back({4'hC, gain_of(m_cur), m_cur, m_cur});
        m_cur = (m_cur == m_last) ? m_first : m_cur + 1'b1;
    endtask

    task automatic soft_conv();
        expect_one();
        wr(4'h0, 8'h00);
        repeat (8) @(negedge clk);
    endtask

    task automatic pulse(bit which_ext);
        @(negedge clk);
        if (which_ext) ext_trig = 1'b1; else pacer_trig = 1'b1;
        @(negedge clk);
        ext_trig = 1'b0; pacer_trig = 1'b0;
    endtask

    // Converter model: answers each request after a short latency.
    initial begin
        conv_done = 1'b0; conv_data = '0;
        forever begin
            @(negedge clk);
            if (conv_req) begin
                automatic logic [3:0] ch = conv_chan;
                automatic logic [3:0] g  = conv_gain;
                n_req++;
                repeat (3) @(negedge clk);
                conv_done = 1'b1; conv_data = {4'hC, g, ch};
                @(negedge clk);
                conv_done = 1'b0;
            end
        end
    end

    // Monitor: compare every result strobe against the queue (R4, R2, R8).
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            if (exp_q.size() == 0) begin
                n_chk++; n_bad++;
                $display("FAIL R9: unexpected result %h expected none", res_word);
            end else begin
                check("R4 result word", res_word, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int req0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11 reset state
        rd(4'h8, rv); check("R11 status", rv, 8'h20);
        rd(4'h9, rv); check("R11 ctrl", rv, 8'h00);
        rd(4'h2, rv); check("R11 window", rv, 8'h00);
        check("R11 irq", irq_out, 0);
        // R2 load gain codes for every channel
        for (int c = 0; c < 16; c++) begin
            wr(4'h2, 8'(c));
            wr(4'h1, {4'h0, gain_of(4'(c))});
        end
        // R7 control readback, bit 3 dropped
        wr(4'h9, 8'hBD); rd(4'h9, rv); check("R7 ctrl", rv, 8'hB5);
        check("R7 irq_line", irq_line, 3'd3);
        wr(4'h9, 8'hB1);
        // R1 window readback and pointer
        set_window(4'd3, 4'd5);
        rd(4'h2, rv); check("R1 window", rv, 8'h53);
        rd(4'h8, rv); check("R1 next chan", rv, 8'h23);
        // R3 software conversion, R10 interrupt, R5 status
        soft_conv();
        check("R10 irq set", irq_out, 1);
        rd(4'h8, rv); check("R5 status after done", rv, 8'hB4);
        wr(4'h8, 8'h00);
        check("R10 irq cleared", irq_out, 0);
        rd(4'h8, rv); check("R6 pending cleared", rv, 8'hA4);
        // R8 step and wrap inside window
        soft_conv(); soft_conv(); soft_conv();
        rd(4'h8, rv); check("R8 wrap to first", rv[3:0], 4'd4);
        // R4 byte split of last result (channel 3)
        rd(4'h0, rv); check("R4 low byte", rv, 8'h33);
        rd(4'h1, rv); check("R4 high byte", rv, {4'hC, gain_of(4'd3)});
        // R8 window through channel 15
        set_window(4'd14, 4'd1);
        for (int k = 0; k < 5; k++) soft_conv();
        rd(4'h8, rv); check("R8 wrap 15 to 0 ptr", rv[3:0], m_cur);
        // R10 interrupt disabled keeps irq low while pending; R5 uni strap
        wr(4'h9, 8'h01);
        uni_mode = 1'b1;
        soft_conv();
        check("R10 irq gated", irq_out, 0);
        rd(4'h8, rv); check("R5 status uni", rv[7:4], 4'hF);
        // R9 mode 0 ignores every trigger
        wr(4'h9, 8'h00);
        req0 = n_req;
        wr(4'h0, 8'h00); pulse(1); pulse(0);
        repeat (10) @(negedge clk);
        check("R9 mode off", 16'(n_req - req0), 16'd0);
        rd(4'h8, rv); check("R9 pointer kept", rv[3:0], m_cur);
        // R9 external mode: second pulse while busy, pacer and soft ignored
        wr(4'h9, 8'h02);
        req0 = n_req;
        expect_one();
        pulse(1); pulse(1); wr(4'h0, 8'h00);
        repeat (10) @(negedge clk);
        pulse(0);
        repeat (10) @(negedge clk);
        check("R9 ext busy ignore", 16'(n_req - req0), 16'd1);
        // R9 pacer mode
        wr(4'h9, 8'h03);
        req0 = n_req;
        expect_one();
        pulse(0); pulse(1);
        repeat (10) @(negedge clk);
        check("R9 pacer", 16'(n_req - req0), 16'd1);
        check("R4 queue drained", 16'(exp_q.size()), 16'd0);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule